// File: doc/BRIEF.md
# Dual-Clock Single-Word Mailbox

This block hands one data word from a producing processor to a consuming processor whose clocks are independent and unrelated. The producer writes the word to a fixed mailbox address on its own bus; the block latches it, reports itself occupied to the producer, and some consumer clocks later raises a level doorbell interrupt toward the consumer. The consumer reads the mailbox address, which returns the word and frees the slot. The producer then sees the slot empty again a few of its own clocks later.

While the slot is occupied, further producer writes to the mailbox are refused: the stored word stays as it was and a sticky error interrupt is raised toward the producer, which clears it by writing to a separate clear address. Occupancy is held as two toggle bits, one per clock domain, each passed to the other side through a multi-flop synchronizer. No flop is driven from both clocks, and the data register is only ever sampled by the consumer while the producer is locked out of it.

Top module: `dc_mailbox`

## Requirements
- R1: After both resets, the producer occupancy output, the doorbell, the error interrupt and the consumer read data are all 0.
- R2: A producer write strobe with the low DEC_W address bits equal to MBOX_ADDR (default 0) while the slot is empty stores the word, and the producer occupancy output is 1 after that same producer clock edge.
- R3: A producer write to the mailbox address while the slot is occupied leaves the stored word unchanged.
- R4: A producer write to the mailbox address while the slot is occupied sets the error interrupt, which stays 1 until cleared.
- R5: A consumer read strobe on the mailbox address while the doorbell is 1 returns the stored word on the read data output in that cycle, drops the doorbell after that consumer edge, and the producer occupancy output returns to 0 within SYNC_STAGES+2 producer clocks.
- R6: A producer write strobe to CLR_ADDR (default 1) clears the error interrupt on the next producer edge and does not touch the slot.
- R7: After an accepted write the doorbell rises within SYNC_STAGES+2 consumer clocks, and while it is 1 the read data output equals the stored word and holds steady.
- R8: While the doorbell is 0 the consumer read data output is 0, and a consumer read then changes nothing.
- R9: Producer writes to any other address, and strobe-free bus activity, change neither the slot, the occupancy nor the error interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_clk | input | 1 | Producer clock |
| p_rst_n | input | 1 | Producer asynchronous reset, active low |
| p_addr | input | AW | Producer bus address |
| p_wr | input | 1 | Producer write strobe |
| p_wdata | input | DW | Producer write data |
| p_full | output | 1 | Slot occupied, producer view |
| p_err_irq | output | 1 | Sticky refused-write interrupt to producer |
| c_clk | input | 1 | Consumer clock |
| c_rst_n | input | 1 | Consumer asynchronous reset, active low |
| c_addr | input | AW | Consumer bus address |
| c_rd | input | 1 | Consumer read strobe |
| c_rdata | output | DW | Mailbox word while occupied, else 0 |
| c_doorbell | output | 1 | New-data interrupt to consumer (level) |

## Verification
The bench goes after writes into an occupied slot: a design that let them through would change the word the consumer later reads, and one that forgot the error bit would leave the producer interrupt low. It reads an empty slot, where a faulty toggle update would flip occupancy and conjure a phantom doorbell, and it writes to unrelated addresses, which a loose decode would turn into mailbox writes. It also bounds the doorbell and release latencies, catching a synchronizer chain that is too long or a side that never sees the other's toggle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // Decoded producer bus operation
   typedef struct packed {
      logic put;     // write strobe hits the mailbox
      logic clear;   // write strobe hits the error-clear address
   } prod_op_t;

   localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_prod_side.sv
module mbox_prod_side
   import mbox_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned AW        = 4,
   parameter int unsigned DEC_W     = 4,
   parameter int unsigned MBOX_ADDR = 0,
   parameter int unsigned CLR_ADDR  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          remote_tog,   // consumer toggle, synchronized
   output logic          local_tog,
   output logic [DW-1:0] word_q,
   output logic          full,
   output logic          err_irq
);
   localparam logic [DEC_W-1:0] MBOX_KEY = DEC_W'(MBOX_ADDR);
   localparam logic [DEC_W-1:0] CLR_KEY  = DEC_W'(CLR_ADDR);

   prod_op_t op;
   logic     accept;
   logic     refuse;

   always_comb begin
      op.put   = wr && (addr[DEC_W-1:0] == MBOX_KEY);
      op.clear = wr && (addr[DEC_W-1:0] == CLR_KEY);
   end

   assign full   = local_tog ^ remote_tog;
   assign accept = op.put && !full;
   assign refuse = op.put && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         local_tog <= 1'b0;
         word_q    <= '0;
      end else if (accept) begin
         local_tog <= ~local_tog;
         word_q    <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_irq <= 1'b0;
      else if (refuse) err_irq <= 1'b1;
      else if (op.clear) err_irq <= 1'b0;
   end

   // R2: an accepted write makes the slot occupied
   a_r2_full_after_put: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> full);
   // R3: refused write keeps the word
   a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> $stable(word_q));
   // R4: refused write raises the error
   a_r4_err_set: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> err_irq);
   // R6: clear write drops the error
   a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (op.clear && !refuse) |=> !err_irq);
   // R9: no strobe, no change to slot or error
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(word_q) && $stable(local_tog) && !$rose(err_irq)));
endmodule

// File: rtl/mbox_cons_side.sv
module mbox_cons_side #(
   parameter int unsigned DW        = 16,
   parameter int unsigned AW        = 4,
   parameter int unsigned DEC_W     = 4,
   parameter int unsigned MBOX_ADDR = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          rd,
   input  logic          remote_tog,   // producer toggle, synchronized
   input  logic [DW-1:0] word_q,       // producer-domain register
   output logic          local_tog,
   output logic          pending,
   output logic [DW-1:0] rdata
);
   localparam logic [DEC_W-1:0] MBOX_KEY = DEC_W'(MBOX_ADDR);

   logic take;

   assign pending = local_tog ^ remote_tog;
   assign take    = rd && (addr[DEC_W-1:0] == MBOX_KEY) && pending;
   assign rdata   = pending ? word_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    local_tog <= 1'b0;
      else if (take) local_tog <= ~local_tog;
   end

   // R5: a read of a pending word releases it
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !pending);
   // R8: a read of an empty slot changes nothing
   a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !pending) |=> $stable(local_tog));
endmodule

// File: rtl/dc_mailbox.sv
module dc_mailbox
   import mbox_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned AW          = 4,
   parameter int unsigned DEC_W       = 4,
   parameter int unsigned MBOX_ADDR   = 0,
   parameter int unsigned CLR_ADDR    = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          p_clk,
   input  logic          p_rst_n,
   input  logic [AW-1:0] p_addr,
   input  logic          p_wr,
   input  logic [DW-1:0] p_wdata,
   output logic          p_full,
   output logic          p_err_irq,
   input  logic          c_clk,
   input  logic          c_rst_n,
   input  logic [AW-1:0] c_addr,
   input  logic          c_rd,
   output logic [DW-1:0] c_rdata,
   output logic          c_doorbell
);
   localparam int unsigned KEY_SPAN = 1 << DEC_W;

   generate
      if (DEC_W > AW || DEC_W == 0) begin : g_bad_dec
         $error("DEC_W must be in 1..AW");
      end
      if (MBOX_ADDR >= KEY_SPAN || CLR_ADDR >= KEY_SPAN || MBOX_ADDR == CLR_ADDR) begin : g_bad_addr
         $error("MBOX_ADDR and CLR_ADDR must be distinct and fit in DEC_W bits");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DW == 0) begin : g_bad_dw
         $error("DW must be nonzero");
      end
   endgenerate

   logic          p_tog, c_tog;
   logic          p_tog_at_c, c_tog_at_p;
   logic [DW-1:0] word_q;

   mbox_prod_side #(
      .DW(DW), .AW(AW), .DEC_W(DEC_W), .MBOX_ADDR(MBOX_ADDR), .CLR_ADDR(CLR_ADDR)
   ) u_prod (
      .clk(p_clk), .rst_n(p_rst_n), .addr(p_addr), .wr(p_wr), .wdata(p_wdata),
      .remote_tog(c_tog_at_p), .local_tog(p_tog), .word_q(word_q),
      .full(p_full), .err_irq(p_err_irq)
   );

   mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_p2c (
      .clk(c_clk), .rst_n(c_rst_n), .d(p_tog), .q(p_tog_at_c)
   );

   mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_c2p (
      .clk(p_clk), .rst_n(p_rst_n), .d(c_tog), .q(c_tog_at_p)
   );

   mbox_cons_side #(
      .DW(DW), .AW(AW), .DEC_W(DEC_W), .MBOX_ADDR(MBOX_ADDR)
   ) u_cons (
      .clk(c_clk), .rst_n(c_rst_n), .addr(c_addr), .rd(c_rd),
      .remote_tog(p_tog_at_c), .word_q(word_q), .local_tog(c_tog),
      .pending(c_doorbell), .rdata(c_rdata)
   );

   // R7: the word seen by the consumer holds while the doorbell is up
   a_r7_word_steady: assert property (@(posedge c_clk) disable iff (!c_rst_n || !p_rst_n)
      (c_doorbell && !c_rd) |=> $stable(c_rdata));
   // R1: reset state of producer outputs
   a_r1_prod_reset: assert property (@(posedge p_clk)
      $rose(p_rst_n) |-> (!p_full && !p_err_irq));
endmodule

// File: tb/dc_mailbox_tb.sv
module dc_mailbox_tb;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int SYNC = 2;

   logic          p_clk = 1'b0, c_clk = 1'b0;
   logic          p_rst_n = 1'b0, c_rst_n = 1'b0;
   logic [AW-1:0] p_addr = '0, c_addr = '0;
   logic          p_wr = 1'b0, c_rd = 1'b0;
   logic [DW-1:0] p_wdata = '0;
   logic          p_full, p_err_irq, c_doorbell;
   logic [DW-1:0] c_rdata;

   int checks = 0, failures = 0;
   int p_cycles = 0;
   bit m_full = 0, m_err = 0;
   logic [DW-1:0] m_word = '0;

   always #10 p_clk = ~p_clk;   // 50 MHz
   always #17 c_clk = ~c_clk;

   dc_mailbox #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC)) u_dut (
      .p_clk(p_clk), .p_rst_n(p_rst_n), .p_addr(p_addr), .p_wr(p_wr),
      .p_wdata(p_wdata), .p_full(p_full), .p_err_irq(p_err_irq),
      .c_clk(c_clk), .c_rst_n(c_rst_n), .c_addr(c_addr), .c_rd(c_rd),
      .c_rdata(c_rdata), .c_doorbell(c_doorbell)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_rdata(input bit full, input logic [DW-1:0] w);
      return full ? w : '0;
   endfunction

   task automatic settle();
      repeat (8) @(negedge c_clk);
      @(negedge p_clk);
   endtask

   task automatic check_state(input string req);
      check(p_full == m_full, {req, " p_full"}, 32'(p_full), 32'(m_full));
      check(c_doorbell == m_full, {req, " doorbell"}, 32'(c_doorbell), 32'(m_full));
      check(p_err_irq == m_err, {req, " err"}, 32'(p_err_irq), 32'(m_err));
      check(c_rdata == exp_rdata(m_full, m_word), {req, " rdata"}, 32'(c_rdata),
            32'(exp_rdata(m_full, m_word)));
   endtask

   // producer write, with model update and latency checks
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit was_full = m_full;
      @(negedge p_clk);
      p_addr = a; p_wdata = d; p_wr = 1'b1;
      @(negedge p_clk);
      p_wr = 1'b0;
      if (a == 0) begin
         if (was_full) begin
            m_err = 1;
            check(p_err_irq == 1'b1, "R4 err after refused write", 32'(p_err_irq), 1);
         end else begin
            m_full = 1; m_word = d;
            check(p_full == 1'b1, "R2 full after accepted write", 32'(p_full), 1);
            begin
               int n = 0;
               while (!c_doorbell && n < 10) begin @(negedge c_clk); n++; end
               check(n <= SYNC + 2, "R7 doorbell latency", 32'(n), 32'(SYNC + 2));
            end
         end
      end else if (a == 1) begin
         m_err = 0;
         check(p_err_irq == 1'b0, "R6 err cleared", 32'(p_err_irq), 0);
      end
      settle();
   endtask

   task automatic do_read();
      bit was_full = m_full;
      @(negedge c_clk);
      c_addr = '0;
      check(c_rdata == exp_rdata(m_full, m_word), was_full ? "R5 read data" : "R8 empty read data",
            32'(c_rdata), 32'(exp_rdata(m_full, m_word)));
      c_rd = 1'b1;
      @(negedge c_clk);
      c_rd = 1'b0;
      m_full = 0;
      check(c_doorbell == 1'b0, "R5 doorbell drops after read", 32'(c_doorbell), 0);
      begin
         int n = 0;
         while (p_full && n < 10) begin @(negedge p_clk); n++; end
         check(n <= SYNC + 2, "R5 producer release latency", 32'(n), 32'(SYNC + 2));
      end
      settle();
   endtask

   initial begin : watchdog
      forever begin
         @(posedge p_clk);
         p_cycles++;
         if (p_cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : stim
      void'($urandom(32'd4711));
      repeat (3) @(negedge p_clk);
      p_rst_n = 1'b1;
      @(negedge c_clk);
      c_rst_n = 1'b1;
      settle();
      check_state("R1 reset");

      // directed corners
      do_read();                          // R8 read of empty slot
      check_state("R8 after empty read");
      do_write(4'd5, 16'hBEEF);           // R9 unrelated address
      check_state("R9 other address");
      do_write(4'd0, 16'h1234);           // R2 accept
      check_state("R2 stored");
      do_write(4'd0, 16'hDEAD);           // R3/R4 refuse
      check_state("R3 word kept");
      do_write(4'd0, 16'h5555);           // R4 sticky, still refused
      check_state("R4 sticky");
      do_write(4'd1, 16'h0000);           // R6 clear
      check_state("R6 cleared, slot intact");
      do_read();                          // R5
      check_state("R5 released");
      do_write(4'd0, 16'h0000);           // zero word
      do_read();
      check_state("R5 zero word");

      // random mix
      for (int i = 0; i < 60; i++) begin
         int op = int'($urandom % 5);
         logic [DW-1:0] d = DW'($urandom);
         case (op)
            0, 1: do_write(4'd0, d);
            2:    do_read();
            3:    do_write(4'd1, d);
            default: do_write(AW'(2 + ($urandom % 14)), d);
         endcase
         check_state("R9 random state");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule